// File: doc/BRIEF.md
# Dual-Channel Audio Serial Interrupt Generator

This block tracks the data buffers of a two-channel audio serial port and raises its data interrupts. On the transmit side, each channel holds either one word (a single holding register) or up to `DEPTH` words (a FIFO), depending on a FIFO-enable input. The host fills the channel with write strobes and the serializer drains it with pop strobes. The block keeps an empty flag and an underrun flag for each channel. The receive side works the other way round: the serializer pushes words in, the host reads them out, and the block keeps a ready flag and an overrun flag for each channel.

Each channel drives two transmit interrupts and two receive interrupts. The exception interrupt fires when the channel needs service and its error flag (underrun or overrun) is set. The normal interrupt fires when the channel needs service and no error is pending. The transmit empty flag is always live, even while the transmitter is disabled. The transmit interrupts, however, need both the transmit interrupt enable and the transmitter enable. In single-channel mode, channel 1 is frozen and its interrupts stay low.

Top module: `aud_irq_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, both `tx_empty` bits read 1 and every other output bit reads 0.
- R2: A host write to a transmit channel is accepted when that channel holds fewer words than its capacity. An accepted write makes `tx_empty` read 0 after the clock edge. A write to a full channel is dropped. `tx_empty` reads 1 again once the last word has been popped.
- R3: `tx_empty` follows the channel occupancy whatever the value of `tx_en`. While `tx_en` is 0, serializer pops are ignored: the occupancy is unchanged and no underrun is raised.
- R4: A pop while `tx_en` is 1 and the transmit channel is empty sets `tx_under` for that channel. A `clr_tx_under` pulse clears the flag. A set and a clear in the same cycle leave the flag set.
- R5: `irq_tx_norm[c]` is 1 exactly when `tx_ie`, `tx_en` and `tx_empty[c]` are 1, `tx_under[c]` is 0, and channel c is active. It changes in the same cycle as the flags it depends on.
- R6: `irq_tx_exc[c]` is 1 exactly when `tx_ie`, `tx_en`, `tx_empty[c]` and `tx_under[c]` are all 1 and channel c is active. The two transmit interrupts of a channel are never high together.
- R7: If either `tx_ie` or `tx_en` is 0 at a clock edge, every transmit interrupt output is 0 after that edge.
- R8: `rx_ready[c]` reads 1 when receive channel c holds at least one word. A push into a full channel is dropped and sets `rx_over[c]`. A host read of an empty channel has no effect.
- R9: A `clr_rx_over` pulse clears `rx_over` for its channel. A new overrun in the same cycle wins.
- R10: `irq_rx_exc[c]` is `rx_ie & rx_ready[c] & rx_over[c]`, and `irq_rx_norm[c]` is `rx_ie & rx_ready[c] & ~rx_over[c]`, both gated by channel c being active.
- R11: When `dual_mode` is 0, channel 1 is inactive: its host and serializer strobes are ignored and its four interrupt outputs are 0. Channel 0 is always active.
- R12: Channel capacity is 1 word when `fifo_en` is 0 and `DEPTH` words (15 by default) when `fifo_en` is 1. Capacity applies in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| fifo_en | input | 1 | 1: FIFO capacity per channel; 0: single holding register |
| dual_mode | input | 1 | 1: both channels active; 0: channel 0 only |
| host_tx_wr | input | 2 | Host write strobe per transmit channel |
| ser_tx_pop | input | 2 | Serializer pop strobe per transmit channel |
| host_rx_rd | input | 2 | Host read strobe per receive channel |
| ser_rx_push | input | 2 | Serializer push strobe per receive channel |
| clr_tx_under | input | 2 | Write-one-to-clear for the underrun flags |
| clr_rx_over | input | 2 | Write-one-to-clear for the overrun flags |
| tx_empty | output | 2 | Transmit channel empty flag |
| tx_under | output | 2 | Transmit underrun flag |
| rx_ready | output | 2 | Receive data available flag |
| rx_over | output | 2 | Receive overrun flag |
| irq_tx_norm | output | 2 | Transmit data interrupt, no exception |
| irq_tx_exc | output | 2 | Transmit data interrupt with underrun |
| irq_rx_norm | output | 2 | Receive data interrupt, no exception |
| irq_rx_exc | output | 2 | Receive data interrupt with overrun |

## Verification
The bench goes after the capacity edges in both FIFO settings. A design that miscounted capacity would either accept a second word in holding-register mode or drop the sixteenth-minus-one word in FIFO mode, and would then report empty or ready one pop or read early or late. It also checks a pop with the transmitter disabled, which a careless design would count as an underrun. It checks a set and a clear of an error flag in the same cycle, where a design with the wrong priority would lose the error. It checks the split between the exception and normal interrupts. Getting those conditions wrong would raise both interrupts at once, or raise neither. A long pseudo-random sweep over the enables, the mode bits and all strobes, compared against an arithmetic occupancy model, catches channel 1 leaking through in single-channel mode and interrupts that lag their flags by a cycle.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int NUM_CH = 2;

    // Occupancy step selected from the two qualified strobes.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_DOWN = 2'b01,
        STEP_UP   = 2'b10,
        STEP_SWAP = 2'b11
    } step_t;

    typedef struct packed {
        logic exc;
        logic norm;
    } irq_pair_t;

    function automatic step_t step_of(input logic up, input logic down);
        return step_t'({up, down});
    endfunction

endpackage

// File: rtl/aud_tx_track.sv
module aud_tx_track
    import aud_irq_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en_i,
    input  logic tx_en_i,
    input  logic wr_i,
    input  logic pop_i,
    input  logic clr_i,
    output logic empty_o,
    output logic under_o,
    output logic empty_nx_o,
    output logic under_nx_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count_q, count_d, cap;
    logic          wr_ok, pop_req, pop_ok;
    step_t         step;

    always_comb begin
        cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
        wr_ok   = wr_i && (count_q < cap);
        pop_req = pop_i && tx_en_i;
        pop_ok  = pop_req && (count_q != '0);
        step    = step_of(wr_ok, pop_ok);
        unique case (step)
            STEP_UP:   count_d = count_q + CW'(1);
            STEP_DOWN: count_d = count_q - CW'(1);
            default:   count_d = count_q;
        endcase
        under_nx_o = (under_o && !clr_i) || (pop_req && (count_q == '0));
        empty_nx_o = (count_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            empty_o <= 1'b1;
            under_o <= 1'b0;
        end else begin
            count_q <= count_d;
            empty_o <= empty_nx_o;
            under_o <= under_nx_o;
        end
    end

    assert_depth_bound_R12: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));
    assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (count_q < cap)) |=> !empty_o);
    assert_underrun_set_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && tx_en_i && empty_o) |=> under_o);
    assert_idle_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_i && !wr_i) |=> $stable(count_q));

endmodule

// File: rtl/aud_rx_track.sv
module aud_rx_track
    import aud_irq_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en_i,
    input  logic push_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic ready_o,
    output logic over_o,
    output logic ready_nx_o,
    output logic over_nx_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count_q, count_d, cap;
    logic          push_ok, rd_ok;
    step_t         step;

    always_comb begin
        cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
        push_ok = push_i && (count_q < cap);
        rd_ok   = rd_i && (count_q != '0);
        step    = step_of(push_ok, rd_ok);
        unique case (step)
            STEP_UP:   count_d = count_q + CW'(1);
            STEP_DOWN: count_d = count_q - CW'(1);
            default:   count_d = count_q;
        endcase
        over_nx_o  = (over_o && !clr_i) || (push_i && !push_ok);
        ready_nx_o = (count_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            ready_o <= 1'b0;
            over_o  <= 1'b0;
        end else begin
            count_q <= count_d;
            ready_o <= ready_nx_o;
            over_o  <= over_nx_o;
        end
    end

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && (count_q >= cap)) |=> over_o);
    assert_last_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !push_i && (count_q == CW'(1))) |=> !ready_o);
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (over_o && !clr_i) |=> over_o);

endmodule

// File: rtl/aud_irq_pair.sv
module aud_irq_pair
    import aud_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      svc_nx_i,
    input  logic      err_nx_i,
    output irq_pair_t pair_o
);
    irq_pair_t pair_d;

    always_comb begin
        pair_d.exc  = en_i && svc_nx_i && err_nx_i;
        pair_d.norm = en_i && svc_nx_i && !err_nx_i;
    end

    always_ff @(posedge clk) begin
        if (rst) pair_o <= '0;
        else     pair_o <= pair_d;
    end

    assert_pair_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(pair_o.exc && pair_o.norm));
    assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (pair_o == '0));

endmodule

// File: rtl/aud_irq_gen.sv
module aud_irq_gen
    import aud_irq_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              tx_ie,
    input  logic              rx_ie,
    input  logic              fifo_en,
    input  logic              dual_mode,
    input  logic [NUM_CH-1:0] host_tx_wr,
    input  logic [NUM_CH-1:0] ser_tx_pop,
    input  logic [NUM_CH-1:0] host_rx_rd,
    input  logic [NUM_CH-1:0] ser_rx_push,
    input  logic [NUM_CH-1:0] clr_tx_under,
    input  logic [NUM_CH-1:0] clr_rx_over,
    output logic [NUM_CH-1:0] tx_empty,
    output logic [NUM_CH-1:0] tx_under,
    output logic [NUM_CH-1:0] rx_ready,
    output logic [NUM_CH-1:0] rx_over,
    output logic [NUM_CH-1:0] irq_tx_norm,
    output logic [NUM_CH-1:0] irq_tx_exc,
    output logic [NUM_CH-1:0] irq_rx_norm,
    output logic [NUM_CH-1:0] irq_rx_exc
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic      active;
        logic      empty_nx, under_nx, ready_nx, over_nx;
        irq_pair_t tx_pair, rx_pair;

        assign active = (ch == 0) ? 1'b1 : dual_mode;

        aud_tx_track #(.DEPTH(DEPTH)) u_tx (
            .clk        (clk),
            .rst        (rst),
            .fifo_en_i  (fifo_en),
            .tx_en_i    (tx_en),
            .wr_i       (host_tx_wr[ch] && active),
            .pop_i      (ser_tx_pop[ch] && active),
            .clr_i      (clr_tx_under[ch]),
            .empty_o    (tx_empty[ch]),
            .under_o    (tx_under[ch]),
            .empty_nx_o (empty_nx),
            .under_nx_o (under_nx)
        );

        aud_rx_track #(.DEPTH(DEPTH)) u_rx (
            .clk        (clk),
            .rst        (rst),
            .fifo_en_i  (fifo_en),
            .push_i     (ser_rx_push[ch] && active),
            .rd_i       (host_rx_rd[ch] && active),
            .clr_i      (clr_rx_over[ch]),
            .ready_o    (rx_ready[ch]),
            .over_o     (rx_over[ch]),
            .ready_nx_o (ready_nx),
            .over_nx_o  (over_nx)
        );

        aud_irq_pair u_tx_irq (
            .clk      (clk),
            .rst      (rst),
            .en_i     (tx_ie && tx_en && active),
            .svc_nx_i (empty_nx),
            .err_nx_i (under_nx),
            .pair_o   (tx_pair)
        );

        aud_irq_pair u_rx_irq (
            .clk      (clk),
            .rst      (rst),
            .en_i     (rx_ie && active),
            .svc_nx_i (ready_nx),
            .err_nx_i (over_nx),
            .pair_o   (rx_pair)
        );

        assign irq_tx_exc[ch]  = tx_pair.exc;
        assign irq_tx_norm[ch] = tx_pair.norm;
        assign irq_rx_exc[ch]  = rx_pair.exc;
        assign irq_rx_norm[ch] = rx_pair.norm;
    end

    assert_single_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |=> !(irq_tx_exc[1] || irq_tx_norm[1] || irq_rx_exc[1] || irq_rx_norm[1]));
    assert_tx_irq_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_tx_norm[0] || irq_tx_exc[0]) |-> tx_empty[0]);
    assert_rx_irq_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_rx_norm[0] || irq_rx_exc[0]) |-> rx_ready[0]);

endmodule

// File: tb/tb_aud_irq_gen.sv
`timescale 1ns/1ps
module tb_aud_irq_gen;
    localparam int DEPTH = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 0, tx_ie = 0, rx_ie = 0, fifo_en = 0, dual_mode = 0;
    logic [1:0] host_tx_wr = 0, ser_tx_pop = 0, host_rx_rd = 0, ser_rx_push = 0;
    logic [1:0] clr_tx_under = 0, clr_rx_over = 0;
    logic [1:0] tx_empty, tx_under, rx_ready, rx_over;
    logic [1:0] irq_tx_norm, irq_tx_exc, irq_rx_norm, irq_rx_exc;

    int checks = 0, failures = 0;
    int tcnt[2], rcnt[2];
    logic tund[2], rovr[2];
    bit done = 0;

    always #4 clk = ~clk;

    aud_irq_gen #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string req, input string scen, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s) actual=%b expected=%b at %0t", req, scen, act, exp, $time);
        end
    endtask

    task automatic check_all(input string scen);
        logic [1:0] e_emp, e_und, e_rdy, e_ovr, e_tn, e_te, e_rn, e_re;
        for (int c = 0; c < 2; c++) begin
            bit act = (c == 0) || dual_mode;
            e_emp[c] = (tcnt[c] == 0);
            e_und[c] = tund[c];
            e_rdy[c] = (rcnt[c] != 0);
            e_ovr[c] = rovr[c];
            e_tn[c]  = act && tx_ie && tx_en && e_emp[c] && !e_und[c];
            e_te[c]  = act && tx_ie && tx_en && e_emp[c] && e_und[c];
            e_rn[c]  = act && rx_ie && e_rdy[c] && !e_ovr[c];
            e_re[c]  = act && rx_ie && e_rdy[c] && e_ovr[c];
        end
        chk("R2 tx_empty", scen, tx_empty, e_emp);
        chk("R4 tx_under", scen, tx_under, e_und);
        chk("R8 rx_ready", scen, rx_ready, e_rdy);
        chk("R9 rx_over", scen, rx_over, e_ovr);
        chk("R5 irq_tx_norm", scen, irq_tx_norm, e_tn);
        chk("R6 irq_tx_exc", scen, irq_tx_exc, e_te);
        chk("R10 irq_rx_norm", scen, irq_rx_norm, e_rn);
        chk("R10 irq_rx_exc", scen, irq_rx_exc, e_re);
    endtask

    // One clock with the given strobes; model updated from pre-edge state.
    task automatic cyc(input logic [1:0] w, input logic [1:0] p, input logic [1:0] r,
                       input logic [1:0] s, input logic [1:0] cu, input logic [1:0] co,
                       input string scen);
        int cap = fifo_en ? DEPTH : 1;
        host_tx_wr = w; ser_tx_pop = p; host_rx_rd = r; ser_rx_push = s;
        clr_tx_under = cu; clr_rx_over = co;
        for (int c = 0; c < 2; c++) begin
            bit act = (c == 0) || dual_mode;
            bit wok = act && w[c] && (tcnt[c] < cap);
            bit preq = act && p[c] && tx_en;
            bit pok = preq && (tcnt[c] > 0);
            bit sreq = act && s[c];
            bit sok = sreq && (rcnt[c] < cap);
            bit rok = act && r[c] && (rcnt[c] > 0);
            tund[c] = (tund[c] && !cu[c]) || (preq && tcnt[c] == 0);
            rovr[c] = (rovr[c] && !co[c]) || (sreq && !sok);
            tcnt[c] = tcnt[c] + int'(wok) - int'(pok);
            rcnt[c] = rcnt[c] + int'(sok) - int'(rok);
        end
        @(posedge clk); #1;
        host_tx_wr = 0; ser_tx_pop = 0; host_rx_rd = 0; ser_rx_push = 0;
        clr_tx_under = 0; clr_rx_over = 0;
        check_all(scen);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        for (int c = 0; c < 2; c++) begin tcnt[c] = 0; rcnt[c] = 0; tund[c] = 0; rovr[c] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 during reset");
        rst = 0;
        @(posedge clk); #1;
        check_all("R1 after release");

        // Holding-register mode, single channel
        tx_en = 1; tx_ie = 1; rx_ie = 1;
        @(posedge clk); #1;
        check_all("R5 empty after enable");
        cyc(2'b01, 0, 0, 0, 0, 0, "R2 first write");
        cyc(2'b01, 0, 0, 0, 0, 0, "R12 second write dropped");
        cyc(0, 2'b01, 0, 0, 0, 0, "R2 pop to empty");
        cyc(0, 2'b01, 0, 0, 0, 0, "R4 underrun");
        cyc(2'b01, 0, 0, 0, 2'b01, 0, "R4 clear with write");
        cyc(0, 2'b01, 0, 0, 0, 0, "R2 pop");
        cyc(0, 2'b01, 0, 0, 2'b01, 0, "R4 set beats clear");
        cyc(0, 0, 0, 0, 2'b01, 0, "R4 clear");
        cyc(2'b10, 2'b10, 2'b10, 2'b10, 0, 0, "R11 ch1 ignored single");

        // Transmitter disabled / masks
        tx_en = 0;
        cyc(0, 2'b01, 0, 0, 0, 0, "R3 pop ignored tx off");
        cyc(2'b01, 0, 0, 0, 0, 0, "R3 flag live tx off");
        cyc(0, 2'b01, 0, 0, 0, 0, "R3 pop ignored holds word");
        tx_en = 1;
        cyc(0, 2'b01, 0, 0, 0, 0, "R7 reenabled pop");
        tx_ie = 0;
        cyc(0, 2'b01, 0, 0, 0, 0, "R7 tx_ie masks exc");
        tx_ie = 1;
        cyc(0, 0, 0, 0, 2'b01, 0, "R7 unmask");

        // Receive holding register
        cyc(0, 0, 0, 2'b01, 0, 0, "R8 push");
        cyc(0, 0, 0, 2'b01, 0, 0, "R8 push overrun R12");
        cyc(0, 0, 2'b01, 0, 0, 2'b01, "R9 read and clear");
        cyc(0, 0, 2'b01, 0, 0, 0, "R8 read empty ignored");

        // FIFO mode, both channels, fill past capacity and drain past empty
        fifo_en = 1; dual_mode = 1;
        for (int c = 0; c < 2; c++) begin
            logic [1:0] m = 2'b01 << c;
            for (int i = 0; i < DEPTH + 2; i++) cyc(m, 0, 0, m, 0, 0, "R12 FIFO fill");
            for (int i = 0; i < DEPTH + 1; i++) cyc(0, m, m, 0, 0, 0, "R12 FIFO drain");
            cyc(0, 0, 0, 0, m, m, "R9 clear flags");
        end

        // Pseudo-random sweep of enables, modes and strobes
        for (int i = 0; i < 6000; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[31:29] == 3'b000) begin
                tx_en = seed[3]; tx_ie = seed[4]; rx_ie = seed[5];
                fifo_en = seed[6]; dual_mode = seed[7];
            end
            cyc(seed[9:8], seed[11:10], seed[13:12], seed[15:14],
                seed[17:16] & {2{seed[28]}}, seed[19:18] & {2{seed[27]}}, "R11 sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule